// File: doc/BRIEF.md
# Latched Fault Protection Sequencer

This block sits behind the analog comparators of an off-line flyback controller and decides, cycle by cycle, whether the switching output may run. Each comparator flag feeds a clock-driven debounce timer. A timer that reaches its window latches the output off and records a cause code. The over-current path uses a single timer with an early checkpoint. If the supply has sagged when the checkpoint is reached, the fault is classed as a short circuit. Otherwise the timer keeps counting to a much longer over-current window. The two thermistor thresholds use a short window at normal load and a longer one at light load.

Around the timers sits a three-state supply sequencer: idle (start-up source charging the supply), running, and latched. It applies turn-on/turn-off hysteresis. While latched, it hops the start-up source between a low restart level and the turn-on level, and it clears the latch only when the supply drops below the release level. All windows are parameters counted in clock cycles.

Top module: `prot_seq`

## Requirements
- R1: After reset the output enable is 0, the start-up source enable is 1 and the fault code is 0 (none).
- R2: While idle, the supply turn-on flag moves the block to running on the next edge: output enable 1, start-up source 0. The two enables are never both 1.
- R3: While running, the turn-off flag returns the block to idle (output 0, source 1) without recording a fault.
- R4: Sense above the over-current level for T_SCP consecutive running cycles, with the short-circuit supply flag set on that cycle, latches off with code 1.
- R5: With the supply not sagged at the checkpoint, sense held for T_OCP cycles latches off with code 2. A sag that appears after the checkpoint does not change the class.
- R6: Supply over-voltage held for T_OVP cycles latches off with code 3.
- R7: The second (lower) thermistor level held for T_OT2_NRM cycles at normal load, or T_OT2_LGT at light load, latches off with code 4.
- R8: The first thermistor level held for T_OT1_NRM cycles at normal load, or T_OT1_LGT at light load, latches off with code 5.
- R9: Feedback above the open-loop level held for T_OLP cycles latches off with code 6.
- R10: A condition that drops before its window ends restarts that timer from zero.
- R11: While latched, the code keeps the first fault and the output stays 0. Later fault flags and the turn-on flag have no effect on either.
- R12: While latched, the start-up source turns on when the restart flag is seen, stays on until the turn-on flag, then turns off.
- R13: The release flag, while latched, clears the code to 0 and returns the block to idle with the source on.
- R14: Timers count only while running. When several timers expire on the same edge, the lowest code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_over_oc | input | 1 | Current sense above over-current level |
| vdd_above_on | input | 1 | Supply above turn-on level |
| vdd_below_off | input | 1 | Supply below turn-off level |
| vdd_below_sc | input | 1 | Supply below short-circuit level |
| vdd_above_ov | input | 1 | Supply above over-voltage level |
| vdd_below_restart | input | 1 | Supply below start-up restart level |
| vdd_below_release | input | 1 | Supply below latch release level |
| ntc_below_t1 | input | 1 | Thermistor voltage below first level |
| ntc_below_t2 | input | 1 | Thermistor voltage below second level |
| fb_above_open | input | 1 | Feedback above open-loop level |
| light_load | input | 1 | Light-load indication (selects long thermal windows) |
| pwm_en | output | 1 | Switching output enable |
| hv_en | output | 1 | Start-up source enable |
| fault_code | output | 3 | Latched fault cause, 0 = none |

## Verification
Each fault flag is held for every duration from one cycle up to one past its window, then dropped. This shows the exact cycle on which the latch fires, and it separates an off-by-one window from a correct one. The over-current path is swept three ways: sagged throughout, never sagged, and sagged only after the checkpoint. Together these separate the short-circuit branch from the long over-current branch. The thermal flags are swept at both load settings to show that the window selection is correct. Separate patterns cover a broken condition (timer restart), two timers expiring together (priority), conditions held while idle (no counting), and the restart/turn-on hopping of the source while latched.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } seq_state_e;

  localparam int NUM_FAULTS = 6;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_SCP  = 3'd1,
    FC_OCP  = 3'd2,
    FC_OVP  = 3'd3,
    FC_OT2  = 3'd4,
    FC_OT1  = 3'd5,
    FC_OLP  = 3'd6
  } fault_code_e;
endpackage

// File: rtl/dbnc_timer.sv
module dbnc_timer #(
  parameter int LIM_A = 16,
  parameter int LIM_B = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cond,
  input  logic sel_b,
  output logic fire
);
  localparam int LMAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CW   = $clog2(LMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim_m1;
  logic          active;

  always_comb begin
    lim_m1 = sel_b ? CW'(LIM_B - 1) : CW'(LIM_A - 1);
    active = en && cond;
    fire   = active && (cnt_q >= lim_m1);
    cnt_d  = (active && !fire) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/oc_timer.sv
module oc_timer #(
  parameter int MARK = 4,
  parameter int LIM  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cond,
  input  logic sag,
  output logic scp_fire,
  output logic ocp_fire
);
  localparam int CW = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          active;

  always_comb begin
    active   = en && cond;
    scp_fire = active && sag && (cnt_q == CW'(MARK - 1));
    ocp_fire = active && (cnt_q == CW'(LIM - 1));
    cnt_d    = (active && !ocp_fire && !scp_fire) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fault_pick.sv
module fault_pick
  import prot_pkg::*;
#(
  parameter int N = NUM_FAULTS
) (
  input  logic [N-1:0] hits,
  output logic         any,
  output logic [2:0]   code
);
  always_comb begin
    any  = |hits;
    code = 3'd0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) code = 3'(i + 1);
    end
  end
endmodule

// File: rtl/prot_seq.sv
module prot_seq
  import prot_pkg::*;
#(
  parameter int T_SCP     = 1875000,
  parameter int T_OCP     = 26875000,
  parameter int T_OVP     = 20000,
  parameter int T_OT1_NRM = 2000000,
  parameter int T_OT1_LGT = 6375000,
  parameter int T_OT2_NRM = 23125,
  parameter int T_OT2_LGT = 75625,
  parameter int T_OLP     = 26875000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_over_oc,
  input  logic       vdd_above_on,
  input  logic       vdd_below_off,
  input  logic       vdd_below_sc,
  input  logic       vdd_above_ov,
  input  logic       vdd_below_restart,
  input  logic       vdd_below_release,
  input  logic       ntc_below_t1,
  input  logic       ntc_below_t2,
  input  logic       fb_above_open,
  input  logic       light_load,
  output logic       pwm_en,
  output logic       hv_en,
  output logic [2:0] fault_code
);
  seq_state_e st_q, st_d;
  logic       hv_q, hv_d;
  logic [2:0] code_q, code_d;
  logic       run;
  logic [NUM_FAULTS-1:0] hits;
  logic       hit_any;
  logic [2:0] hit_code;

  assign run = (st_q == ST_RUN);

  oc_timer #(.MARK(T_SCP), .LIM(T_OCP)) u_oc (
    .clk(clk), .rst_n(rst_n), .en(run), .cond(cs_over_oc), .sag(vdd_below_sc),
    .scp_fire(hits[0]), .ocp_fire(hits[1])
  );

  dbnc_timer #(.LIM_A(T_OVP), .LIM_B(T_OVP)) u_ov (
    .clk(clk), .rst_n(rst_n), .en(run), .cond(vdd_above_ov), .sel_b(1'b0),
    .fire(hits[2])
  );

  dbnc_timer #(.LIM_A(T_OT2_NRM), .LIM_B(T_OT2_LGT)) u_ot2 (
    .clk(clk), .rst_n(rst_n), .en(run), .cond(ntc_below_t2), .sel_b(light_load),
    .fire(hits[3])
  );

  dbnc_timer #(.LIM_A(T_OT1_NRM), .LIM_B(T_OT1_LGT)) u_ot1 (
    .clk(clk), .rst_n(rst_n), .en(run), .cond(ntc_below_t1), .sel_b(light_load),
    .fire(hits[4])
  );

  dbnc_timer #(.LIM_A(T_OLP), .LIM_B(T_OLP)) u_olp (
    .clk(clk), .rst_n(rst_n), .en(run), .cond(fb_above_open), .sel_b(1'b0),
    .fire(hits[5])
  );

  fault_pick #(.N(NUM_FAULTS)) u_pick (
    .hits(hits), .any(hit_any), .code(hit_code)
  );

  // next-state
  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    unique case (st_q)
      ST_IDLE: if (vdd_above_on) st_d = ST_RUN;
      ST_RUN: begin
        if (hit_any) begin
          st_d   = ST_LATCH;
          code_d = hit_code;
        end else if (vdd_below_off) begin
          st_d = ST_IDLE;
        end
      end
      ST_LATCH: begin
        if (vdd_below_release) begin
          st_d   = ST_IDLE;
          code_d = 3'd0;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    case (st_d)
      ST_IDLE:  hv_d = 1'b1;
      ST_RUN:   hv_d = 1'b0;
      default: begin
        if (st_q != ST_LATCH)       hv_d = 1'b0;
        else if (vdd_below_restart) hv_d = 1'b1;
        else if (vdd_above_on)      hv_d = 1'b0;
        else                        hv_d = hv_q;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hv_q   <= 1'b1;
      code_q <= 3'd0;
    end else begin
      st_q   <= st_d;
      hv_q   <= hv_d;
      code_q <= code_d;
    end
  end

  assign pwm_en     = run;
  assign hv_en      = hv_q;
  assign fault_code = code_q;
endmodule

// File: rtl/prot_seq_chk.sv
module prot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_over_oc,
  input logic       vdd_above_on,
  input logic       vdd_below_off,
  input logic       vdd_below_sc,
  input logic       vdd_above_ov,
  input logic       vdd_below_restart,
  input logic       vdd_below_release,
  input logic       ntc_below_t1,
  input logic       ntc_below_t2,
  input logic       fb_above_open,
  input logic       light_load,
  input logic       pwm_en,
  input logic       hv_en,
  input logic [2:0] fault_code
);
  assert_src_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_en && hv_en));

  assert_start_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> $past(vdd_above_on));

  assert_stop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_en) |-> ($past(vdd_below_off) || fault_code != 3'd0));

  assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 3'd0 && !vdd_below_release) |=> $stable(fault_code));

  assert_latched_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 3'd0) |-> !pwm_en);

  assert_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 3'd0 && vdd_below_release) |=> (fault_code == 3'd0 && hv_en));
endmodule

bind prot_seq prot_seq_chk u_chk (.*);

// File: tb/sim_prot_seq.sv
module sim_prot_seq;
  localparam int P_SCP = 3, P_OCP = 7, P_OVP = 4;
  localparam int P_OT1N = 5, P_OT1L = 9, P_OT2N = 2, P_OT2L = 4, P_OLP = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cs, von, voff, vsc, vov, vrst, vrel, t1, t2, fb, ll;
  logic pwm_en, hv_en;
  logic [2:0] fault_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  prot_seq #(
    .T_SCP(P_SCP), .T_OCP(P_OCP), .T_OVP(P_OVP),
    .T_OT1_NRM(P_OT1N), .T_OT1_LGT(P_OT1L),
    .T_OT2_NRM(P_OT2N), .T_OT2_LGT(P_OT2L), .T_OLP(P_OLP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cs_over_oc(cs), .vdd_above_on(von),
    .vdd_below_off(voff), .vdd_below_sc(vsc), .vdd_above_ov(vov),
    .vdd_below_restart(vrst), .vdd_below_release(vrel),
    .ntc_below_t1(t1), .ntc_below_t2(t2), .fb_above_open(fb),
    .light_load(ll), .pwm_en(pwm_en), .hv_en(hv_en), .fault_code(fault_code)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_c(int k, logic v);
    case (k)
      1: cs = v;
      3: vov = v;
      4: t2 = v;
      5: t1 = v;
      6: fb = v;
      default: ;
    endcase
  endtask

  task automatic recover();
    vrel = 1'b1; cyc(1); vrel = 1'b0;
    von  = 1'b1; cyc(1); von  = 1'b0;
  endtask

  // hold fault k for dur running cycles, then drop it and compare
  task automatic scen(int k, int dur, logic load, logic sag, string req);
    int lim;
    int exp;
    ll = load;
    set_c(k, 1'b1); vsc = sag;
    cyc(dur);
    set_c(k, 1'b0); vsc = 1'b0;
    cyc(1);
    case (k)
      1: exp = sag ? ((dur >= P_SCP) ? 1 : 0) : ((dur >= P_OCP) ? 2 : 0);
      3: exp = (dur >= P_OVP) ? 3 : 0;
      4: begin lim = load ? P_OT2L : P_OT2N; exp = (dur >= lim) ? 4 : 0; end
      5: begin lim = load ? P_OT1L : P_OT1N; exp = (dur >= lim) ? 5 : 0; end
      default: exp = (dur >= P_OLP) ? 6 : 0;
    endcase
    chk({req, " code"}, fault_code, exp);
    chk({req, " pwm"}, pwm_en, (exp == 0) ? 1 : 0);
    chk({req, " hv"}, hv_en, 0);
    recover();
    ll = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {cs, von, voff, vsc, vov, vrst, vrel, t1, t2, fb, ll} = '0;
    cyc(3);
    // R1 reset state
    chk("R1 pwm", pwm_en, 0);
    chk("R1 hv", hv_en, 1);
    chk("R1 code", fault_code, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R2 idle holds", pwm_en, 0);
    von = 1'b1; cyc(1); von = 1'b0;
    chk("R2 pwm on", pwm_en, 1);
    chk("R2 hv off", hv_en, 0);

    // R3 undervoltage lockout
    voff = 1'b1; cyc(1); voff = 1'b0;
    chk("R3 pwm off", pwm_en, 0);
    chk("R3 hv on", hv_en, 1);
    chk("R3 no code", fault_code, 0);
    von = 1'b1; cyc(1); von = 1'b0;

    // R4 / R5 over-current sweeps
    for (int d = 1; d <= P_OCP + 1; d++) scen(1, d, 1'b0, 1'b1, "R4 scp sweep");
    for (int d = 1; d <= P_OCP + 1; d++) scen(1, d, 1'b0, 1'b0, "R5 ocp sweep");
    // R5 sag only after the checkpoint
    cs = 1'b1; cyc(P_SCP); vsc = 1'b1; cyc(P_OCP - P_SCP - 1);
    chk("R5 late sag no latch yet", pwm_en, 1);
    cyc(1); cs = 1'b0; vsc = 1'b0;
    chk("R5 late sag class", fault_code, 2);
    recover();

    // R6 .. R9 sweeps
    for (int d = 1; d <= P_OVP + 1; d++) scen(3, d, 1'b0, 1'b0, "R6 ovp sweep");
    for (int d = 1; d <= P_OT2L + 1; d++) begin
      scen(4, d, 1'b0, 1'b0, "R7 ot2 normal");
      scen(4, d, 1'b1, 1'b0, "R7 ot2 light");
    end
    for (int d = 1; d <= P_OT1L + 1; d++) begin
      scen(5, d, 1'b0, 1'b0, "R8 ot1 normal");
      scen(5, d, 1'b1, 1'b0, "R8 ot1 light");
    end
    for (int d = 1; d <= P_OLP + 1; d++) scen(6, d, 1'b0, 1'b0, "R9 olp sweep");

    // R10 broken condition restarts the timer
    vov = 1'b1; cyc(P_OVP - 1); vov = 1'b0; cyc(1);
    vov = 1'b1; cyc(P_OVP - 1); vov = 1'b0; cyc(1);
    chk("R10 restart no latch", pwm_en, 1);
    chk("R10 restart code", fault_code, 0);

    // R11 / R12 latched behaviour
    vov = 1'b1; cyc(P_OVP); vov = 1'b0;
    chk("R11 first fault", fault_code, 3);
    cs = 1'b1; vsc = 1'b1; t2 = 1'b1; fb = 1'b1; cyc(P_OLP + 2);
    cs = 1'b0; vsc = 1'b0; t2 = 1'b0; fb = 1'b0;
    chk("R11 later faults ignored", fault_code, 3);
    chk("R12 hv off on entry", hv_en, 0);
    vrst = 1'b1; cyc(1); vrst = 1'b0;
    chk("R12 hv on at restart", hv_en, 1);
    cyc(3);
    chk("R12 hv held", hv_en, 1);
    von = 1'b1; cyc(1); von = 1'b0;
    chk("R12 hv off at turn-on", hv_en, 0);
    chk("R11 turn-on ignored", pwm_en, 0);
    chk("R11 code kept", fault_code, 3);

    // R13 release
    vrel = 1'b1; cyc(1); vrel = 1'b0;
    chk("R13 code cleared", fault_code, 0);
    chk("R13 hv on", hv_en, 1);
    chk("R13 pwm off", pwm_en, 0);

    // R14 no counting while idle
    fb = 1'b1; cyc(10);
    chk("R14 idle no latch", fault_code, 0);
    von = 1'b1; cyc(1); von = 1'b0;
    cyc(P_OLP - 1);
    chk("R14 window from run start", pwm_en, 1);
    cyc(1); fb = 1'b0;
    chk("R14 olp after full window", fault_code, 6);
    recover();

    // R14 simultaneous expiry: ovp and ot2 (light) share a window
    ll = 1'b1; vov = 1'b1; t2 = 1'b1; cyc(P_OVP);
    vov = 1'b0; t2 = 1'b0; ll = 1'b0;
    chk("R14 priority", fault_code, 3);
    recover();
    chk("R2 rerun", pwm_en, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule